// File: doc/BRIEF.md
# Hashed Page-Table Group Search Engine

This block walks one group of eight translation entries held in memory and reports whether any of them maps the requested page with the rights the access needs. A caller pulses a start input with the group's base address, the tag it expects in each entry's first word, the hash-select bit of the group (primary or secondary), the access kind (read or write), the protection key of the current privilege level and the entry format (32-bit words or 64-bit words). Hashing the address into a group base and caching the outcome are left to the caller.

The engine fetches each entry's first word through a read port with a valid/ready request and a single-beat response. Only when that word is valid, carries the requested hash bit and matches the tag does it fetch the second word, which holds the real page number, two protection bits and the referenced and changed flags. A granting entry ends the walk at once. A matching entry that refuses the access is remembered, and the walk goes on in case a later entry grants. Two matching entries that name different real pages make the group inconsistent and the search ends as a miss. After a hit or a violation the engine updates the flags of the chosen entry and writes its second word back only if the word changed.

Top module: `pteg_search`

## Requirements
- R1: After reset `busy_o`, `done_o`, `rd_valid_o` and `wr_valid_o` are all low.
- R2: Entry i's first word is read at base + i*8 (32-bit format) or base + i*16 (64-bit format); its second word at that address + 4 or + 8, and the second word is read only for an entry whose first word matches. The read and write ports are never active together. A search with no matching entry makes exactly 8 reads, the first at the base.
- R3: An entry matches when its valid bit is 1, its hash bit equals `hsel_i`, and all other bits of the first word equal `tag_i`. Valid and hash bits are bits 31 and 6 in 32-bit format (upper 32 bits of the response ignored) and bits 0 and 1 in 64-bit format.
- R4: A matching entry that grants the access ends the walk: no further reads, `status_o` = 1 (hit), `idx_o` = its index.
- R5: A matching entry that refuses the access does not end the walk; if no later entry grants, the result is `status_o` = 2 (violation) with the most recent refusing index, and a later granting entry with the same real page gives a hit on that later entry.
- R6: If a matching entry names a real page (second-word bits above 11) different from a previously refused entry, the search ends with `status_o` = 0 (miss), `data_o` = 0 and no write. A search without any match also returns miss with `data_o` = 0.
- R7: On hit or violation the referenced flag (second-word bit 8) is set, and the changed flag (bit 7) is set only for a granted write; `data_o` carries the updated second word, and it is written back to the entry's second-word address only if it differs from the stored word.
- R8: Rights from protection bits pp (second-word bits 1:0) and `key_i`: key 0 gives read/write for pp 0, 1, 2 and read only for pp 3; key 1 gives nothing for pp 0, read only for pp 1 and 3, read/write for pp 2.
- R9: `busy_o` rises the cycle after an accepted start and stays high until `done_o`, which is high for exactly one cycle and falls together with `busy_o`.
- R10: A read or write request holds its valid and address stable until ready is seen, and results do not depend on how long ready is withheld.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, taken when idle |
| fmt64_i | input | 1 | 1: 64-bit entry format, 0: 32-bit format |
| base_i | input | ADDR_W | Byte address of the group |
| tag_i | input | 64 | Expected first-word contents apart from valid and hash bits |
| hsel_i | input | 1 | Required hash bit (secondary group) |
| wr_i | input | 1 | Access is a write |
| key_i | input | 1 | Protection key |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 2 | 0 miss, 1 hit, 2 violation |
| idx_o | output | IDX_W | Index of the chosen entry |
| data_o | output | 64 | Updated second word of the chosen entry |
| rd_valid_o | output | 1 | Read request valid |
| rd_ready_i | input | 1 | Read request accepted |
| rd_addr_o | output | ADDR_W | Read byte address |
| rsp_valid_i | input | 1 | Read data valid |
| rsp_data_i | input | 64 | Read data |
| wr_valid_o | output | 1 | Write request valid |
| wr_ready_i | input | 1 | Write request accepted |
| wr_addr_o | output | ADDR_W | Write byte address |
| wr_data_o | output | 64 | Write data |

## Verification
The hardest situation to reach is a group holding a refused entry followed by a matching entry: whether that ends as a hit or as an inconsistency miss depends only on the two real page numbers, so the bench builds groups with a read-only entry early and a writable entry late, once with equal and once with different page numbers, and drives a write. The write-back decision is reached by searching the same group twice, so the second search finds the flags already set and must stay off the write port. The rights table is swept on one entry whose flags are preset, so every outcome appears without any write traffic, and a stalling memory model repeats a hit to show the handshakes only add cycles.

// File: rtl/pteg_pkg.sv
package pteg_pkg;

    localparam int unsigned WORD_W  = 64;
    localparam int unsigned HALF_W  = 32;

    // first-word control bits, per format
    localparam int unsigned V32_BIT = 31;
    localparam int unsigned H32_BIT = 6;
    localparam int unsigned V64_BIT = 0;
    localparam int unsigned H64_BIT = 1;

    // second-word fields
    localparam int unsigned REF_BIT = 8;
    localparam int unsigned CHG_BIT = 7;
    localparam int unsigned PG_LSB  = 12;

    // entry geometry
    localparam int unsigned ENT32_SH = 3;
    localparam int unsigned ENT64_SH = 4;
    localparam int unsigned W1_OFF32 = 4;
    localparam int unsigned W1_OFF64 = 8;

    localparam logic [WORD_W-1:0] TAGMASK32 =
        {{HALF_W{1'b0}}, {HALF_W{1'b1}}} & ~(WORD_W'(1) << V32_BIT) & ~(WORD_W'(1) << H32_BIT);
    localparam logic [WORD_W-1:0] TAGMASK64 =
        ~(WORD_W'(1) << V64_BIT) & ~(WORD_W'(1) << H64_BIT);
    localparam logic [WORD_W-1:0] PGMASK = ~((WORD_W'(1) << PG_LSB) - WORD_W'(1));

    typedef enum logic [1:0] {
        RES_MISS = 2'd0,
        RES_HIT  = 2'd1,
        RES_VIOL = 2'd2
    } res_e;

    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_RD0  = 3'd1,
        S_WT0  = 3'd2,
        S_RD1  = 3'd3,
        S_WT1  = 3'd4,
        S_FLAG = 3'd5,
        S_WB   = 3'd6,
        S_DONE = 3'd7
    } st_e;

endpackage

// File: rtl/pteg_addr_gen.sv
module pteg_addr_gen #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned IDX_W  = 3
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic              fmt64_i,
    input  logic              second_i,
    output logic [ADDR_W-1:0] addr_o
);
    import pteg_pkg::*;

    logic [ADDR_W-1:0] ent_off;
    logic [ADDR_W-1:0] word_off;

    always_comb begin
        ent_off  = fmt64_i ? (ADDR_W'(idx_i) << ENT64_SH) : (ADDR_W'(idx_i) << ENT32_SH);
        word_off = '0;
        if (second_i) begin
            word_off = fmt64_i ? ADDR_W'(W1_OFF64) : ADDR_W'(W1_OFF32);
        end
        addr_o = base_i + ent_off + word_off;
    end
endmodule

// File: rtl/pteg_match.sv
module pteg_match (
    input  logic [63:0] word_i,
    input  logic [63:0] tag_i,
    input  logic        hsel_i,
    input  logic        fmt64_i,
    output logic        match_o
);
    import pteg_pkg::*;

    logic              vld;
    logic              hbit;
    logic [WORD_W-1:0] mask;

    always_comb begin
        vld     = fmt64_i ? word_i[V64_BIT] : word_i[V32_BIT];
        hbit    = fmt64_i ? word_i[H64_BIT] : word_i[H32_BIT];
        mask    = fmt64_i ? TAGMASK64 : TAGMASK32;
        match_o = vld && (hbit == hsel_i) && ((word_i & mask) == (tag_i & mask));
    end
endmodule

// File: rtl/pteg_rights.sv
module pteg_rights (
    input  logic [1:0] pp_i,
    input  logic       key_i,
    input  logic       wr_i,
    output logic       grant_o
);
    logic rd_ok;
    logic wr_ok;

    always_comb begin
        if (!key_i) begin
            rd_ok = 1'b1;
            wr_ok = (pp_i != 2'd3);
        end else begin
            rd_ok = (pp_i != 2'd0);
            wr_ok = (pp_i == 2'd2);
        end
        grant_o = wr_i ? wr_ok : rd_ok;
    end

    always_comb begin
        if (!$isunknown({pp_i, key_i})) begin
            AST_WRITE_IMPLIES_READ: assert (!wr_ok || rd_ok); // R8
        end
    end
endmodule

// File: rtl/pteg_flags.sv
module pteg_flags (
    input  logic [63:0] w1_i,
    input  logic        granted_i,
    input  logic        wr_i,
    output logic [63:0] w1_o,
    output logic        changed_o
);
    import pteg_pkg::*;

    always_comb begin
        w1_o = w1_i;
        w1_o[REF_BIT] = 1'b1;
        if (granted_i && wr_i) begin
            w1_o[CHG_BIT] = 1'b1;
        end
        changed_o = (w1_o != w1_i);
    end

    always_comb begin
        if (!$isunknown(w1_i)) begin
            AST_FLAGS_ONLY_GROW: assert ((w1_o & w1_i) == w1_i); // R7
        end
    end
endmodule

// File: rtl/pteg_search.sv
module pteg_search #(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned N_ENTRY = 8,
    localparam int unsigned IDX_W  = $clog2(N_ENTRY)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic              fmt64_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [63:0]       tag_i,
    input  logic              hsel_i,
    input  logic              wr_i,
    input  logic              key_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [1:0]        status_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic [63:0]       data_o,
    output logic              rd_valid_o,
    input  logic              rd_ready_i,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic              rsp_valid_i,
    input  logic [63:0]       rsp_data_i,
    output logic              wr_valid_o,
    input  logic              wr_ready_i,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [63:0]       wr_data_o
);
    import pteg_pkg::*;

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_ENTRY - 1);

    typedef struct packed {
        st_e               st;
        logic [IDX_W-1:0]  idx;
        logic              fmt64;
        logic [ADDR_W-1:0] base;
        logic [63:0]       tag;
        logic              hsel;
        logic              wr;
        logic              key;
        logic              vfound;
        logic [IDX_W-1:0]  vidx;
        logic [63:0]       vw1;
        res_e              status;
        logic [IDX_W-1:0]  ridx;
        logic [63:0]       rw1;
    } eng_t;

    eng_t eng_d, eng_q;

    logic [63:0]       rsp_w;
    logic              ent_match;
    logic              ent_grant;
    logic [63:0]       upd_w1;
    logic              upd_changed;
    logic [IDX_W-1:0]  addr_idx;
    logic              addr_second;
    logic [ADDR_W-1:0] port_addr;
    logic              advance;
    logic              page_clash;

    // response word with the unused half cleared in 32-bit format
    assign rsp_w = eng_q.fmt64 ? rsp_data_i : {{HALF_W{1'b0}}, rsp_data_i[HALF_W-1:0]};

    assign addr_idx    = (eng_q.st == S_WB) ? eng_q.ridx : eng_q.idx;
    assign addr_second = (eng_q.st == S_RD1) || (eng_q.st == S_WB);

    pteg_addr_gen #(
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W)
    ) i_addr (
        .base_i   (eng_q.base),
        .idx_i    (addr_idx),
        .fmt64_i  (eng_q.fmt64),
        .second_i (addr_second),
        .addr_o   (port_addr)
    );

    pteg_match i_match (
        .word_i  (rsp_w),
        .tag_i   (eng_q.tag),
        .hsel_i  (eng_q.hsel),
        .fmt64_i (eng_q.fmt64),
        .match_o (ent_match)
    );

    pteg_rights i_rights (
        .pp_i    (rsp_w[1:0]),
        .key_i   (eng_q.key),
        .wr_i    (eng_q.wr),
        .grant_o (ent_grant)
    );

    pteg_flags i_flags (
        .w1_i      (eng_q.rw1),
        .granted_i (eng_q.status == RES_HIT),
        .wr_i      (eng_q.wr),
        .w1_o      (upd_w1),
        .changed_o (upd_changed)
    );

    assign page_clash = eng_q.vfound && ((rsp_w & PGMASK) != (eng_q.vw1 & PGMASK));

    always_comb begin
        eng_d   = eng_q;
        advance = 1'b0;
        case (eng_q.st)
            S_IDLE: begin
                if (start_i) begin
                    eng_d.st     = S_RD0;
                    eng_d.idx    = '0;
                    eng_d.fmt64  = fmt64_i;
                    eng_d.base   = base_i;
                    eng_d.tag    = tag_i;
                    eng_d.hsel   = hsel_i;
                    eng_d.wr     = wr_i;
                    eng_d.key    = key_i;
                    eng_d.vfound = 1'b0;
                    eng_d.vidx   = '0;
                    eng_d.vw1    = '0;
                    eng_d.status = RES_MISS;
                    eng_d.ridx   = '0;
                    eng_d.rw1    = '0;
                end
            end
            S_RD0: begin
                if (rd_ready_i) begin
                    eng_d.st = S_WT0;
                end
            end
            S_WT0: begin
                if (rsp_valid_i) begin
                    if (ent_match) begin
                        eng_d.st = S_RD1;
                    end else begin
                        advance = 1'b1;
                    end
                end
            end
            S_RD1: begin
                if (rd_ready_i) begin
                    eng_d.st = S_WT1;
                end
            end
            S_WT1: begin
                if (rsp_valid_i) begin
                    if (page_clash) begin
                        eng_d.status = RES_MISS;
                        eng_d.ridx   = '0;
                        eng_d.rw1    = '0;
                        eng_d.st     = S_DONE;
                    end else if (ent_grant) begin
                        eng_d.status = RES_HIT;
                        eng_d.ridx   = eng_q.idx;
                        eng_d.rw1    = rsp_w;
                        eng_d.st     = S_FLAG;
                    end else begin
                        eng_d.vfound = 1'b1;
                        eng_d.vidx   = eng_q.idx;
                        eng_d.vw1    = rsp_w;
                        advance      = 1'b1;
                    end
                end
            end
            S_FLAG: begin
                eng_d.rw1 = upd_w1;
                eng_d.st  = upd_changed ? S_WB : S_DONE;
            end
            S_WB: begin
                if (wr_ready_i) begin
                    eng_d.st = S_DONE;
                end
            end
            S_DONE: begin
                eng_d.st = S_IDLE;
            end
            default: begin
                eng_d.st = S_IDLE;
            end
        endcase

        if (advance) begin
            if (eng_q.idx != LAST_IDX) begin
                eng_d.idx = eng_q.idx + IDX_W'(1);
                eng_d.st  = S_RD0;
            end else if (eng_d.vfound) begin
                eng_d.status = RES_VIOL;
                eng_d.ridx   = eng_d.vidx;
                eng_d.rw1    = eng_d.vw1;
                eng_d.st     = S_FLAG;
            end else begin
                eng_d.status = RES_MISS;
                eng_d.rw1    = '0;
                eng_d.st     = S_DONE;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            eng_q <= '0;
        end else begin
            eng_q <= eng_d;
        end
    end

    assign busy_o     = (eng_q.st != S_IDLE);
    assign done_o     = (eng_q.st == S_DONE);
    assign status_o   = eng_q.status;
    assign idx_o      = eng_q.ridx;
    assign data_o     = eng_q.rw1;
    assign rd_valid_o = (eng_q.st == S_RD0) || (eng_q.st == S_RD1);
    assign rd_addr_o  = port_addr;
    assign wr_valid_o = (eng_q.st == S_WB);
    assign wr_addr_o  = port_addr;
    assign wr_data_o  = eng_q.rw1;

    AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_valid_o && !rd_ready_i) |=> (rd_valid_o && $stable(rd_addr_o))); // R10

    AST_WR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_valid_o && !wr_ready_i) |=> (wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o))); // R10

    AST_PORT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(rd_valid_o && wr_valid_o)); // R2

    AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> (!done_o && !busy_o)); // R9

    AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && !busy_o) |=> busy_o); // R9

    AST_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && !done_o) |=> busy_o); // R9

    AST_WB_REF_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_valid_o |-> wr_data_o[REF_BIT]); // R7

    AST_NO_WB_ON_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_valid_o |-> (status_o != RES_MISS)); // R6

    AST_MISS_NO_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && status_o == RES_MISS) |-> (data_o == '0)); // R6

endmodule

// File: tb/test_pteg_search.sv
module test_pteg_search;

    localparam int unsigned ADDR_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              fmt64 = 1'b0;
    logic [ADDR_W-1:0] base = '0;
    logic [63:0]       tag = '0;
    logic              hsel = 1'b0;
    logic              wr = 1'b0;
    logic              key = 1'b0;
    logic              busy, done;
    logic [1:0]        status;
    logic [2:0]        idx;
    logic [63:0]       data;
    logic              rd_valid;
    logic              rd_ready = 1'b0;
    logic [ADDR_W-1:0] rd_addr;
    logic              rsp_valid = 1'b0;
    logic [63:0]       rsp_data = '0;
    logic              wr_valid;
    logic              wr_ready = 1'b0;
    logic [ADDR_W-1:0] wr_addr;
    logic [63:0]       wr_data;

    always #2.5 clk = ~clk;

    pteg_search i_pteg_search (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .fmt64_i(fmt64),
        .base_i(base), .tag_i(tag), .hsel_i(hsel), .wr_i(wr), .key_i(key),
        .busy_o(busy), .done_o(done), .status_o(status), .idx_o(idx), .data_o(data),
        .rd_valid_o(rd_valid), .rd_ready_i(rd_ready), .rd_addr_o(rd_addr),
        .rsp_valid_i(rsp_valid), .rsp_data_i(rsp_data),
        .wr_valid_o(wr_valid), .wr_ready_i(wr_ready), .wr_addr_o(wr_addr), .wr_data_o(wr_data)
    );

    int n_chk = 0;
    int n_fail = 0;

    logic [63:0] mem [logic [31:0]];
    int          n_rd = 0;
    int          n_wr = 0;
    logic [31:0] first_ra = '0;
    logic [31:0] last_wa = '0;
    bit          stall = 1'b0;
    bit          rd_acc = 1'b0;
    bit          wr_acc = 1'b0;
    logic [31:0] acc_ra, acc_wa;
    logic [63:0] acc_wd;
    int          tick = 0;

    logic [1:0]  r_status;
    logic [2:0]  r_idx;
    logic [63:0] r_data;

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // memory model: one request accepted per posedge, response on the next cycle
    initial begin
        forever begin
            @(negedge clk);
            rsp_valid = 1'b0;
            if (rd_acc) begin
                rsp_valid = 1'b1;
                rsp_data  = mem.exists(acc_ra) ? mem[acc_ra] : 64'h0;
                if (n_rd == 0) first_ra = acc_ra;
                n_rd++;
            end
            if (wr_acc) begin
                mem[acc_wa] = acc_wd;
                last_wa     = acc_wa;
                n_wr++;
            end
            tick++;
            rd_ready = stall ? ((tick % 3) == 0) : 1'b1;
            wr_ready = stall ? ((tick % 2) == 0) : 1'b1;
            rd_acc = rd_valid && rd_ready;
            wr_acc = wr_valid && wr_ready;
            acc_ra = rd_addr;
            acc_wa = wr_addr;
            acc_wd = wr_data;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    function automatic logic [63:0] w0_32(bit v, bit h, logic [31:0] t);
        return {32'h0, t | (32'(v) << 31) | (32'(h) << 6)};
    endfunction

    function automatic logic [63:0] w0_64(bit v, bit h, logic [63:0] t);
        return t | {62'h0, h, v};
    endfunction

    function automatic bit rights_ok(bit k, logic [1:0] pp, bit w);
        if (!k) return w ? (pp != 2'd3) : 1'b1;
        return w ? (pp == 2'd2) : (pp != 2'd0);
    endfunction

    task automatic clear_group(input logic [31:0] b);
        for (int i = 0; i < 32; i++) begin
            mem[b + 32'(i * 4)] = 64'h0;
        end
    endtask

    task automatic run_search(input bit f64, input logic [31:0] b, input logic [63:0] t,
                              input bit h, input bit w, input bit k);
        bit seen = 1'b0;
        @(negedge clk); #1;
        n_rd = 0; n_wr = 0;
        fmt64 = f64; base = b; tag = t; hsel = h; wr = w; key = k; start = 1'b1;
        @(negedge clk); #1;
        start = 1'b0;
        chk("R9", "busy after start", 64'(busy), 64'h1);
        for (int c = 0; c < 3000; c++) begin
            if (done) begin
                seen = 1'b1;
                break;
            end
            if (!busy) break;
            @(negedge clk); #1;
        end
        if (!seen) begin
            n_chk++; n_fail++;
            $display("FAIL R9 done not seen: actual 0 expected 1");
        end
        r_status = status; r_idx = idx; r_data = data;
        @(negedge clk); #1;
        chk("R9", "done one cycle", 64'(done), 64'h0);
        chk("R9", "busy falls with done", 64'(busy), 64'h0);
    endtask

    task automatic t_reset;
        chk("R1", "busy at reset", 64'(busy), 64'h0);
        chk("R1", "done at reset", 64'(done), 64'h0);
        chk("R1", "rd_valid at reset", 64'(rd_valid), 64'h0);
        chk("R1", "wr_valid at reset", 64'(wr_valid), 64'h0);
    endtask

    task automatic t_miss32;
        logic [31:0] b = 32'h1000;
        logic [31:0] t = 32'h0012_3400;
        clear_group(b);
        mem[b + 0]  = w0_32(1, 1, t);               // wrong hash
        mem[b + 8]  = w0_32(0, 0, t);               // not valid
        mem[b + 16] = w0_32(1, 0, t ^ 32'h100);     // wrong tag
        mem[b + 24] = {32'hFFFF_FFFF, 32'h0} | w0_32(0, 0, t); // upper half ignored, invalid
        run_search(0, b, {32'h0, t}, 0, 0, 0);
        chk("R6", "miss status", 64'(r_status), 64'h0);
        chk("R6", "miss data", r_data, 64'h0);
        chk("R2", "miss read count", 64'(n_rd), 64'd8);
        chk("R2", "first read at base", 64'(first_ra), 64'(b));
        chk("R3", "no write on miss", 64'(n_wr), 64'h0);
    endtask

    task automatic t_hit32(input bit stalled, input logic [31:0] b);
        logic [31:0] t  = 32'h0ABC_0000;
        logic [63:0] w1 = 64'h1234_5002;
        stall = stalled;
        clear_group(b);
        mem[b + 0]  = w0_32(1, 0, t);               // other hash
        mem[b + 24] = w0_32(1, 1, t);
        mem[b + 28] = w1;
        mem[b + 32] = w0_32(1, 1, t);               // later match never read
        mem[b + 36] = 64'h5555_5002;
        run_search(0, b, {32'h0, t}, 1, 0, 1);
        chk(stalled ? "R10" : "R4", "hit status", 64'(r_status), 64'h1);
        chk("R4", "hit index", 64'(r_idx), 64'd3);
        chk("R2", "reads up to hit", 64'(n_rd), 64'd5);
        chk("R7", "data has referenced", r_data, w1 | 64'h100);
        chk("R7", "one write", 64'(n_wr), 64'h1);
        chk("R2", "write address", 64'(last_wa), 64'(b + 28));
        chk("R7", "stored word", mem[b + 28], w1 | 64'h100);
        run_search(0, b, {32'h0, t}, 1, 0, 1);
        chk("R7", "no write when unchanged", 64'(n_wr), 64'h0);
        chk("R7", "data repeat", r_data, w1 | 64'h100);
        stall = 1'b0;
    endtask

    task automatic t_write64;
        logic [31:0] b  = 32'h4000;
        logic [63:0] t  = 64'h0000_00AB_CDEF_0000;
        logic [63:0] w1 = 64'h0000_0012_3456_7001;
        clear_group(b);
        mem[b + 16] = w0_32(1, 0, t[31:0]);         // 32-bit style valid: not valid in 64-bit
        mem[b + 80] = w0_64(1, 0, t);
        mem[b + 88] = w1;
        run_search(1, b, t, 0, 1, 0);
        chk("R3", "64-bit hit", 64'(r_status), 64'h1);
        chk("R3", "64-bit index", 64'(r_idx), 64'd5);
        chk("R2", "64-bit reads", 64'(n_rd), 64'd7);
        chk("R7", "write sets both flags", r_data, w1 | 64'h180);
        chk("R2", "64-bit write address", 64'(last_wa), 64'(b + 88));
        chk("R7", "64-bit stored", mem[b + 88], w1 | 64'h180);
        b = 32'h5000;
        clear_group(b);
        mem[b + 112] = w0_64(1, 1, t);
        mem[b + 120] = 64'h0000_0077_0000_0003;
        run_search(1, b, t, 1, 0, 0);
        chk("R4", "last entry hit", 64'(r_status), 64'h1);
        chk("R4", "last entry index", 64'(r_idx), 64'd7);
        chk("R2", "last entry reads", 64'(n_rd), 64'd9);
        chk("R2", "last entry write address", 64'(last_wa), 64'(b + 120));
    endtask

    task automatic t_viol32;
        logic [31:0] b  = 32'h3000;
        logic [31:0] t  = 32'h0055_5500;
        logic [63:0] w1 = 64'h7777_7000;
        clear_group(b);
        mem[b + 16] = w0_32(1, 0, t);
        mem[b + 20] = w1;
        run_search(0, b, {32'h0, t}, 0, 1, 1);
        chk("R5", "violation status", 64'(r_status), 64'h2);
        chk("R5", "violation index", 64'(r_idx), 64'd2);
        chk("R5", "scan continued", 64'(n_rd), 64'd9);
        chk("R7", "violation sets referenced only", r_data, w1 | 64'h100);
        chk("R7", "violation write address", 64'(last_wa), 64'(b + 20));
    endtask

    task automatic t_viol_then_hit;
        logic [31:0] b = 32'h6000;
        logic [31:0] t = 32'h0066_0000;
        clear_group(b);
        mem[b + 8]  = w0_32(1, 0, t);
        mem[b + 12] = 64'h8888_8003;                // read only under key 1
        mem[b + 48] = w0_32(1, 0, t);
        mem[b + 52] = 64'h8888_8102;                // read/write, same page
        run_search(0, b, {32'h0, t}, 0, 1, 1);
        chk("R5", "later grant wins", 64'(r_status), 64'h1);
        chk("R5", "later grant index", 64'(r_idx), 64'd6);
        chk("R7", "later grant data", r_data, 64'h8888_8182);
        chk("R5", "reads", 64'(n_rd), 64'd9);
        chk("R7", "refused entry untouched", mem[b + 12], 64'h8888_8003);
        chk("R7", "single write", 64'(n_wr), 64'h1);
    endtask

    task automatic t_incons;
        logic [31:0] b = 32'h7000;
        logic [31:0] t = 32'h0077_0000;
        clear_group(b);
        mem[b + 8]  = w0_32(1, 0, t);
        mem[b + 12] = 64'h8888_8003;
        mem[b + 32] = w0_32(1, 0, t);
        mem[b + 36] = 64'h9999_9002;                // different page
        mem[b + 48] = w0_32(1, 0, t);
        mem[b + 52] = 64'h8888_8002;                // never reached
        run_search(0, b, {32'h0, t}, 0, 1, 1);
        chk("R6", "inconsistent is miss", 64'(r_status), 64'h0);
        chk("R6", "inconsistent data", r_data, 64'h0);
        chk("R6", "abort reads", 64'(n_rd), 64'd7);
        chk("R6", "no write", 64'(n_wr), 64'h0);
    endtask

    task automatic t_rights;
        logic [31:0] b = 32'h8000;
        logic [31:0] t = 32'h0011_0000;
        int bad = 0;
        for (int k = 0; k < 2; k++) begin
            for (int p = 0; p < 4; p++) begin
                for (int w = 0; w < 2; w++) begin
                    clear_group(b);
                    mem[b + 0] = w0_32(1, 0, t);
                    mem[b + 4] = 64'h1111_1180 | 64'(p);
                    run_search(0, b, {32'h0, t}, 0, bit'(w), bit'(k));
                    chk("R8", $sformatf("key %0d pp %0d wr %0d", k, p, w), 64'(r_status),
                        rights_ok(bit'(k), 2'(p), bit'(w)) ? 64'h1 : 64'h2);
                    bad += n_wr;
                end
            end
        end
        chk("R7", "flags preset gives no writes", 64'(bad), 64'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_miss32();
        t_hit32(1'b0, 32'h2000);
        t_write64();
        t_viol32();
        t_viol_then_hit();
        t_incons();
        t_rights();
        t_hit32(1'b1, 32'h9000);  // R10 with stalled ready
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule